// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block sends frames that software has placed in memory as a chain of buffer descriptors. Each descriptor occupies two 32-bit words. The first word holds a 16-bit control field in its upper half and a 16-bit byte count in its lower half. The second word holds the byte address of the buffer. The register block gives the engine a kick pulse. The engine then fetches descriptors one after another and streams each buffer's bytes out on a byte-wide channel. After each buffer it writes the first word back with the ready bit cleared, and it moves on to the next descriptor. It keeps going until it reads a descriptor whose ready bit is clear.

A frame may be split over several buffers, and the last buffer of the frame carries a marker. Bytes are counted across buffers. When a buffer would take the frame past the maximum frame size, the engine takes only as many bytes as fit and pulses a babble event. The ring has no fixed length: a wrap bit in a descriptor sends the engine back to the ring base address. The engine keeps its descriptor pointer between kicks. The pointer is reloaded from the ring base when the base is rewritten or when the MAC enable is low.

The controller is a single state machine with these states:
- `S_IDLE`: waiting for a kick.
- `S_RD_HDR`: fetching the control/count word.
- `S_RD_PTR`: fetching the buffer address.
- `S_CLIP`: sizing the part of the buffer that will be taken.
- `S_RD_DATA`: fetching a data word.
- `S_EMIT`: sending one byte per cycle.
- `S_WRBACK`: writing the control word back.
- `S_EOF`: sending the end marker.
- `S_NEXT`: advancing or wrapping the pointer.

The transitions are:
- `S_IDLE` goes to `S_RD_HDR` on a kick while enabled.
- `S_RD_HDR` goes to `S_RD_PTR` if the ready bit is set, and back to `S_IDLE` if it is clear.
- `S_RD_PTR` goes to `S_CLIP`.
- `S_CLIP` goes to `S_RD_DATA`, or straight to `S_WRBACK` when nothing is taken.
- `S_RD_DATA` goes to `S_EMIT`.
- `S_EMIT` stays put, returns to `S_RD_DATA` at a word boundary, or goes to `S_WRBACK` after the last byte.
- `S_WRBACK` goes to `S_EOF` for a last buffer, and to `S_NEXT` otherwise.
- `S_EOF` goes to `S_NEXT`.
- `S_NEXT` goes to `S_RD_HDR`.

Any state returns to `S_IDLE` while the enable is low. Each memory state waits for the memory acknowledge before it leaves.

Top module: `txr_engine`

## Requirements
- R1: The descriptor at pointer P is read as word P = {control[15:0], count[15:0]} and word P+4 = buffer byte address. The control bits are: bit 15 = ready, bit 13 = wrap, bit 11 = last. If the ready bit is clear, the engine goes idle without writing memory, emitting bytes or raising events. A memory request stays asserted until it is acknowledged.
- R2: Buffer bytes are emitted one per `tx_valid_o` cycle, in increasing address order, from any byte alignment. Within a fetched word, the byte at the lowest address is in bits 31:24. `tx_sof_o` marks the first byte of each frame and no other byte.
- R3: Bytes from consecutive buffers form one frame until a buffer with the last bit is processed. Then `tx_eof_o` pulses for one cycle with `tx_valid_o` low, and `tx_len_o` gives the frame's total byte count, which may be 0. The count restarts after each end marker and whenever the engine stops.
- R4: When the frame count plus a buffer's count exceeds MAX_FRAME, only MAX_FRAME minus the frame count bytes are taken from that buffer, and `ev_babble_o` pulses once.
- R5: `ev_buf_o` pulses once for every processed descriptor. `ev_frame_o` pulses in the end-marker cycle of every frame.
- R6: After a descriptor is processed, its first word is written back to its own address with only the ready bit cleared.
- R7: The next descriptor pointer is the ring base if the wrap bit was set, and the current pointer plus 8 otherwise.
- R8: The pointer is kept between kicks. A pulse on `ring_base_wr_i` reloads it from `ring_base_i`.
- R9: While `mac_en_i` is low, the engine is held idle, the pointer is reloaded from `ring_base_i`, and kicks are ignored.
- R10: After reset, the engine is idle with no memory request, no stream activity and no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mac_en_i | input | 1 | MAC enable level |
| start_i | input | 1 | Kick pulse from the register block |
| ring_base_i | input | ADDR_W | Ring base address register value |
| ring_base_wr_i | input | 1 | Pulse: ring base register written |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of a frame |
| tx_eof_o | output | 1 | End-of-frame marker cycle |
| tx_len_o | output | CNT_W | Frame byte count, valid with `tx_eof_o` |
| ev_buf_o | output | 1 | Buffer-done event pulse |
| ev_frame_o | output | 1 | Frame-done event pulse |
| ev_babble_o | output | 1 | Oversize-frame event pulse |

## Verification
The bench builds the engine with MAX_FRAME set to 24 rather than 2048. With that value, a frame of two short buffers (20 bytes, then 10) crosses the limit, so clipping and the babble event are reached with a few dozen bytes of model memory. The default address width is kept, so the pointer arithmetic and wrap reload run at full width. The buffers start at every byte offset within a word, which exercises the word refetch at each lane boundary.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;
    localparam int CNT_FIELD_W = 16;
    localparam int DESC_BYTES = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_HDR,
        S_RD_PTR,
        S_CLIP,
        S_RD_DATA,
        S_EMIT,
        S_WRBACK,
        S_EOF,
        S_NEXT
    } txr_state_e;

endpackage

// File: rtl/txr_clip.sv
module txr_clip #(
    parameter int MAX_FRAME = 2048,
    parameter int CNT_W     = 12,
    parameter int LEN_W     = 16
) (
    input  logic [CNT_W-1:0] acc_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] take_o,
    output logic             over_o
);
    localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] room;

    always_comb begin
        sum    = SUM_W'(acc_i) + SUM_W'(len_i);
        room   = SUM_W'(MAX_FRAME) - SUM_W'(acc_i);
        over_o = (sum > SUM_W'(MAX_FRAME));
        take_o = over_o ? LEN_W'(room) : len_i;
    end
endmodule

// File: rtl/txr_lane_pick.sv
module txr_lane_pick #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]           word_i,
    input  logic [$clog2(WORD_W/8)-1:0] idx_i,
    output logic [7:0]                  byte_o
);
    localparam int NB = WORD_W / 8;

    logic [7:0] lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = word_i[(NB-1-g)*8 +: 8];
    end

    assign byte_o = lane[idx_i];
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int MAX_FRAME = 2048,
    parameter int ADDR_W    = 32,
    localparam int CNT_W    = $clog2(MAX_FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_en_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              ring_base_wr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_sof_o,
    output logic              tx_eof_o,
    output logic [CNT_W-1:0]  tx_len_o,
    output logic              ev_buf_o,
    output logic              ev_frame_o,
    output logic              ev_babble_o
);
    localparam int LEN_W = CNT_FIELD_W;

    txr_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] buf_q;
    logic [15:0]       flags_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CNT_W-1:0]  acc_q;
    logic [31:0]       word_q;
    logic [LEN_W-1:0]  take;
    logic              over;
    logic [7:0]        pick;

    txr_clip #(
        .MAX_FRAME(MAX_FRAME),
        .CNT_W(CNT_W),
        .LEN_W(LEN_W)
    ) u_clip (
        .acc_i (acc_q),
        .len_i (len_q),
        .take_o(take),
        .over_o(over)
    );

    txr_lane_pick #(.WORD_W(32)) u_pick (
        .word_i(word_q),
        .idx_i (buf_q[1:0]),
        .byte_o(pick)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_RD_HDR;
            S_RD_HDR:  if (mem_ack_i)
                           state_d = mem_rdata_i[16+FLG_READY] ? S_RD_PTR : S_IDLE;
            S_RD_PTR:  if (mem_ack_i) state_d = S_CLIP;
            S_CLIP:    state_d = (take == '0) ? S_WRBACK : S_RD_DATA;
            S_RD_DATA: if (mem_ack_i) state_d = S_EMIT;
            S_EMIT: begin
                if (rem_q == LEN_W'(1))          state_d = S_WRBACK;
                else if (buf_q[1:0] == 2'b11)    state_d = S_RD_DATA;
            end
            S_WRBACK:  if (mem_ack_i)
                           state_d = flags_q[FLG_LAST] ? S_EOF : S_NEXT;
            S_EOF:     state_d = S_NEXT;
            S_NEXT:    state_d = S_RD_HDR;
            default:   state_d = S_IDLE;
        endcase
        if (!mac_en_i) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            buf_q   <= '0;
            flags_q <= '0;
            len_q   <= '0;
            rem_q   <= '0;
            acc_q   <= '0;
            word_q  <= '0;
        end else if (!mac_en_i) begin
            cur_q <= ring_base_i;
            acc_q <= '0;
        end else begin
            if (ring_base_wr_i)
                cur_q <= ring_base_i;
            else if (state_q == S_NEXT)
                cur_q <= flags_q[FLG_WRAP] ? ring_base_i
                                           : cur_q + ADDR_W'(DESC_BYTES);
            unique case (state_q)
                S_RD_HDR: if (mem_ack_i) begin
                    flags_q <= mem_rdata_i[31:16];
                    len_q   <= mem_rdata_i[15:0];
                    if (!mem_rdata_i[16+FLG_READY]) acc_q <= '0;
                end
                S_RD_PTR:  if (mem_ack_i) buf_q <= mem_rdata_i[ADDR_W-1:0];
                S_CLIP:    rem_q <= take;
                S_RD_DATA: if (mem_ack_i) word_q <= mem_rdata_i;
                S_EMIT: begin
                    buf_q <= buf_q + ADDR_W'(1);
                    rem_q <= rem_q - LEN_W'(1);
                    acc_q <= acc_q + CNT_W'(1);
                end
                S_EOF:     acc_q <= '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = cur_q;
        mem_wdata_o = {flags_q & ~(16'h1 << FLG_READY), len_q};
        tx_valid_o  = 1'b0;
        tx_data_o   = pick;
        tx_sof_o    = 1'b0;
        tx_eof_o    = 1'b0;
        tx_len_o    = '0;
        ev_buf_o    = 1'b0;
        ev_frame_o  = 1'b0;
        ev_babble_o = 1'b0;
        unique case (state_q)
            S_RD_HDR:  mem_req_o = 1'b1;
            S_RD_PTR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + ADDR_W'(4);
            end
            S_CLIP:    ev_babble_o = over;
            S_RD_DATA: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {buf_q[ADDR_W-1:2], 2'b00};
            end
            S_EMIT: begin
                tx_valid_o = 1'b1;
                tx_sof_o   = (acc_q == '0);
            end
            S_WRBACK: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                ev_buf_o  = mem_ack_i;
            end
            S_EOF: begin
                tx_eof_o   = 1'b1;
                tx_len_o   = acc_q;
                ev_frame_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !mac_en_i)
        (mem_req_o && !mem_ack_i) |=> mem_req_o);
    // R2
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sof_o |-> tx_valid_o);
    // R3
    eof_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_eof_o && tx_valid_o));
    // R4
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= CNT_W'(MAX_FRAME));
    // R5
    frame_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_o |-> tx_eof_o);
    // R6
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !mem_wdata_o[16+FLG_READY]);
    // R7
    wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !mac_en_i)
        (state_q == S_NEXT && flags_q[FLG_WRAP] && !ring_base_wr_i)
            |=> cur_q == $past(ring_base_i));
endmodule

// File: tb/txr_engine_test.sv
module txr_engine_test;
    localparam int MAXF  = 24;
    localparam int CNT_W = $clog2(MAXF + 1);
    localparam logic [15:0] RDY = 16'h8000;
    localparam logic [15:0] WRP = 16'h2000;
    localparam logic [15:0] LST = 16'h0800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mac_en = 1'b1;
    logic start = 1'b0;
    logic [31:0] base = '0;
    logic base_wr = 1'b0;
    logic mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic tx_valid, tx_sof, tx_eof;
    logic [7:0] tx_data;
    logic [CNT_W-1:0] tx_len;
    logic ev_buf, ev_frame, ev_babble;

    always #4 clk = ~clk;

    txr_engine #(.MAX_FRAME(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .mac_en_i(mac_en), .start_i(start),
        .ring_base_i(base), .ring_base_wr_i(base_wr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_sof_o(tx_sof),
        .tx_eof_o(tx_eof), .tx_len_o(tx_len),
        .ev_buf_o(ev_buf), .ev_frame_o(ev_frame), .ev_babble_o(ev_babble)
    );

    logic [31:0] mem [0:255];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end
        end
    end

    int cap_n = 0, eof_n = 0, txb_n = 0, txf_n = 0, bab_n = 0, req_n = 0, sof_n = 0;
    int last_len = -1;
    logic [7:0] cap_d [0:511];
    logic       cap_s [0:511];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                cap_d[cap_n] = tx_data;
                cap_s[cap_n] = tx_sof;
                cap_n++;
            end
            if (tx_sof) sof_n++;
            if (tx_eof) begin
                eof_n++;
                last_len = int'(tx_len);
            end
            if (ev_buf) txb_n++;
            if (ev_frame) txf_n++;
            if (ev_babble) bab_n++;
            if (mem_req) req_n++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_desc(int a, logic [15:0] fl, logic [15:0] ln, int b);
        mem[a >> 2]       = {fl, ln};
        mem[(a >> 2) + 1] = b;
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    task automatic set_base(int b);
        @(negedge clk) begin base = b; base_wr = 1'b1; end
        @(negedge clk) base_wr = 1'b0;
    endtask

    task automatic check_bytes(string tag, int idx0, int b, int n);
        for (int i = 0; i < n; i++)
            check(tag, int'(cap_d[idx0 + i]), int'(pat(b + i)));
    endtask

    task automatic t_reset();
        check("R10 mem_req", int'(mem_req), 0);
        check("R10 tx_valid", int'(tx_valid), 0);
        check("R10 tx_eof", int'(tx_eof), 0);
        check("R10 events", int'({ev_buf, ev_frame, ev_babble}), 0);
    endtask

    task automatic t_single();
        int c0 = cap_n, e0 = eof_n, b0 = txb_n, f0 = txf_n, s0 = sof_n;
        set_desc(32'h00, RDY | LST, 16'd6, 32'h200);
        set_desc(32'h08, 16'h0, 16'd0, 32'h0);
        kick();
        check("R2 single count", cap_n - c0, 6);
        check_bytes("R2 single bytes", c0, 32'h200, 6);
        check("R2 single sof first", int'(cap_s[c0]), 1);
        check("R2 single sof once", sof_n - s0, 1);
        check("R3 single eof", eof_n - e0, 1);
        check("R3 single len", last_len, 6);
        check("R5 single txb", txb_n - b0, 1);
        check("R5 single txf", txf_n - f0, 1);
        check("R6 single wb", int'(mem[0]), 32'h0800_0006);
        check("R1 idle desc untouched", int'(mem[2]), 0);
    endtask

    task automatic t_resume();
        int c0 = cap_n;
        set_desc(32'h08, RDY | LST, 16'd3, 32'h213);
        set_desc(32'h10, 16'h0, 16'd0, 32'h0);
        kick();
        check("R8 resume count", cap_n - c0, 3);
        check_bytes("R8 resume bytes", c0, 32'h213, 3);
        check("R7 resume step8 wb", int'(mem[2]), 32'h0800_0003);
    endtask

    task automatic t_multi();
        int c0 = cap_n, e0 = eof_n, b0 = txb_n, f0 = txf_n, s0 = sof_n;
        set_desc(32'h10, RDY, 16'd5, 32'h241);
        set_desc(32'h18, RDY | LST, 16'd7, 32'h262);
        set_desc(32'h20, 16'h0, 16'd0, 32'h0);
        kick();
        check("R3 multi count", cap_n - c0, 12);
        check_bytes("R2 multi seg a", c0, 32'h241, 5);
        check_bytes("R2 multi seg b", c0 + 5, 32'h262, 7);
        check("R2 multi sof once", sof_n - s0, 1);
        check("R3 multi eof", eof_n - e0, 1);
        check("R3 multi len", last_len, 12);
        check("R5 multi txb", txb_n - b0, 2);
        check("R5 multi txf", txf_n - f0, 1);
        check("R6 multi wb a", int'(mem[4]), 32'h0000_0005);
        check("R6 multi wb b", int'(mem[6]), 32'h0800_0007);
    endtask

    task automatic t_clip();
        int c0 = cap_n, bb = bab_n;
        set_desc(32'h20, RDY, 16'd20, 32'h300);
        set_desc(32'h28, RDY | LST, 16'd10, 32'h340);
        set_desc(32'h30, 16'h0, 16'd0, 32'h0);
        kick();
        check("R4 clip count", cap_n - c0, MAXF);
        check_bytes("R4 clip seg a", c0, 32'h300, 20);
        check_bytes("R4 clip seg b", c0 + 20, 32'h340, 4);
        check("R4 clip babble", bab_n - bb, 1);
        check("R4 clip len", last_len, MAXF);
        check("R6 clip wb keeps count", int'(mem[10]), 32'h0800_000A);
    endtask

    task automatic t_wrap();
        int c0 = cap_n, b0 = txb_n;
        set_base(32'h80);
        set_desc(32'h80, RDY | WRP | LST, 16'd2, 32'h380);
        set_desc(32'h88, RDY | LST, 16'd2, 32'h390);
        kick();
        check("R7 wrap count", cap_n - c0, 2);
        check_bytes("R7 wrap bytes", c0, 32'h380, 2);
        check("R7 wrap txb", txb_n - b0, 1);
        check("R7 wrap skip next", int'(mem[32'h88 >> 2]), 32'h8800_0002);
        check("R6 wrap wb", int'(mem[32'h80 >> 2]), 32'h2800_0002);
    endtask

    task automatic t_notready();
        int c0 = cap_n, e0 = eof_n, b0 = txb_n, bb = bab_n;
        kick();
        check("R1 nr bytes", cap_n - c0, 0);
        check("R1 nr eof", eof_n - e0, 0);
        check("R1 nr events", (txb_n - b0) + (bab_n - bb), 0);
        check("R1 nr no write", int'(mem[32'h80 >> 2]), 32'h2800_0002);
    endtask

    task automatic t_zero();
        int c0 = cap_n, e0 = eof_n, b0 = txb_n, f0 = txf_n;
        set_base(32'hA0);
        set_desc(32'hA0, RDY | LST, 16'd0, 32'h3A0);
        set_desc(32'hA8, 16'h0, 16'd0, 32'h0);
        kick();
        check("R8 reload zero bytes", cap_n - c0, 0);
        check("R3 zero eof", eof_n - e0, 1);
        check("R3 zero len", last_len, 0);
        check("R5 zero txb", txb_n - b0, 1);
        check("R5 zero txf", txf_n - f0, 1);
    endtask

    task automatic t_disable();
        int c0, r0;
        @(negedge clk) mac_en = 1'b0;
        r0 = req_n;
        c0 = cap_n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 kick ignored req", req_n - r0, 0);
        check("R9 kick ignored bytes", cap_n - c0, 0);
        set_desc(32'hA0, RDY | LST, 16'd1, 32'h3B0);
        @(negedge clk) mac_en = 1'b1;
        kick();
        check("R9 reload count", cap_n - c0, 1);
        check_bytes("R9 reload byte", c0, 32'h3B0, 1);
        check("R9 reload len", last_len, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {pat(4*i), pat(4*i+1), pat(4*i+2), pat(4*i+3)};
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_resume();
        t_multi();
        t_clip();
        t_wrap();
        t_notready();
        t_zero();
        t_disable();
        summary();
        $finish;
    end
endmodule